// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the cycle-control logic and data path of a synchronous burst static memory with a 32-bit word and a parameterised depth. The storage is a register array. On each rising clock edge the block samples the address, three chip selects, two address strobes, an advance input, an all-bytes write input, a byte-write enable and one write lane per byte. From these it classifies the cycle as one of four kinds: deselect, burst start, burst step or burst hold. Each burst cycle is either a read or a write. Writes can cover any set of bytes.

A burst covers four words. The bottom two address bits follow either a linear or an interleaved order. One strobe, meant for a processor, always starts a read. The other strobe, meant for a cache controller, starts a read or a write depending on the write inputs. The bidirectional data bus is split into a read-data output and a drive-enable output. The drive-enable follows the output-enable input without waiting for a clock edge. A static mode input selects how read data leaves the block: through an output register (pipeline) or straight from the array (flow-through). A sleep input suspends all accesses and keeps the stored contents.

Top module: `sbsram_core`

## Requirements
- R1: The device is selected only when cs0_n=0, cs1=1 and cs2_n=0. Any other select pattern with a strobe low is a deselect cycle. A deselect cycle writes nothing, ends the burst, and stops read drive (after one extra cycle in pipeline mode).
- R2: strobe_cpu_n=0 while selected starts a read burst at the external address, whatever the write inputs are.
- R3: strobe_ctl_n=0 with strobe_cpu_n=1 while selected starts a burst at the external address. The burst is a write if the byte-write function is active and a read otherwise.
- R4: wr_all_n=0 writes all four bytes, whatever wr_byte_en_n and lane_wr_n are.
- R5: With wr_all_n=1 and wr_byte_en_n=0, lane_wr_n[0..3]=0 writes bits 7:0, 15:8, 23:16 and 31:24 respectively. With wr_byte_en_n=1, or with no lane low, the cycle is a read.
- R6: With both strobes high during an active burst, advance_n=0 moves to the next burst address and advance_n=1 keeps the current one. Read or write is chosen by the byte-write function. With no burst active (after reset or a deselect) such a cycle accesses nothing.
- R7: The burst keeps the upper address bits. With seq_linear=1 the low two bits are (start + n) mod 4. With seq_linear=0 they are start XOR n. After the fourth address the burst wraps to the start.
- R8: rdata_oe is high only while out_en_n=0 and the data of a read cycle is presented. It follows out_en_n with no clock edge. It is low for writes, deselect and idle cycles.
- R9: With pipe_sel=1, read data appears and is driven after the edge following the read edge. With pipe_sel=0, it appears right after the read edge.
- R10: sleep=1 at an edge blocks any access: no write, no read drive, burst position held, contents kept. sleep=1 also forces rdata_oe low at once.
- R11: A read that starts on the edge after a write to the same address returns the written data, in both output modes.
- R12: After reset no burst is active and rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, starts reads |
| strobe_ctl_n | input | 1 | Controller-side address strobe |
| advance_n | input | 1 | Step burst address when low |
| wr_all_n | input | 1 | Write all bytes when low |
| wr_byte_en_n | input | 1 | Enables the per-lane writes when low |
| lane_wr_n | input | DATA_W/8 | Per-byte write lanes, active low |
| wdata | input | DATA_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby: blocks all accesses |
| pipe_sel | input | 1 | 1 = pipeline output, 0 = flow-through |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The assertions assume that every input is known at each rising edge after reset and that the decode sees at most one strobe outcome per edge. They also assume that sleep is sampled like any other synchronous input. The bench drives all inputs from time zero, changes them only two nanoseconds after an edge, and returns them to a defined idle pattern after each directed operation. The mode inputs change only between bursts, so an output register never holds data from a different mode's read.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    CK_IDLE,
    CK_DESEL,
    CK_BEGIN_RD,
    CK_BEGIN_WR,
    CK_STEP_RD,
    CK_STEP_WR,
    CK_HOLD_RD,
    CK_HOLD_WR
  } cyc_kind_e;

  // low address bits of burst beat c starting from b
  function automatic logic [1:0] seq_map(input logic [1:0] b, input logic [1:0] c,
                                         input logic lin);
    return lin ? (b + c) : (b ^ c);
  endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             advance_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sleep,
  input  logic             burst_live,
  output logic             load_o,
  output logic             step_o,
  output logic             desel_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [LANES-1:0] mask_o
);
  import sbsram_pkg::*;

  cyc_kind_e  kind;
  logic       sel;
  logic       wr_func;

  assign sel = !cs0_n && cs1 && !cs2_n;

  always_comb begin
    if (!wr_all_n)          mask_o = '1;
    else if (!wr_byte_en_n) mask_o = ~lane_wr_n;
    else                    mask_o = '0;
  end

  assign wr_func = |mask_o;

  always_comb begin
    if (sleep)              kind = CK_IDLE;
    else if (!strobe_cpu_n) kind = sel ? CK_BEGIN_RD : CK_DESEL;
    else if (!strobe_ctl_n) kind = !sel ? CK_DESEL : (wr_func ? CK_BEGIN_WR : CK_BEGIN_RD);
    else if (burst_live) begin
      if (!advance_n)       kind = wr_func ? CK_STEP_WR : CK_STEP_RD;
      else                  kind = wr_func ? CK_HOLD_WR : CK_HOLD_RD;
    end else                kind = CK_IDLE;
  end

  assign load_o  = (kind == CK_BEGIN_RD) || (kind == CK_BEGIN_WR);
  assign step_o  = (kind == CK_STEP_RD)  || (kind == CK_STEP_WR);
  assign desel_o = (kind == CK_DESEL);
  assign rd_o    = (kind == CK_BEGIN_RD) || (kind == CK_STEP_RD) || (kind == CK_HOLD_RD);
  assign wr_o    = (kind == CK_BEGIN_WR) || (kind == CK_STEP_WR) || (kind == CK_HOLD_WR);

  // R1: a strobe without full selection never accesses the array
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (!strobe_cpu_n || !strobe_ctl_n) && !sel) |-> (!rd_o && !wr_o && !load_o));

  // R2: processor strobe while selected is always a read start
  p_cpu_strobe_reads_r2: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_cpu_n && sel) |-> (rd_o && load_o && !wr_o));

  // R10: standby cycle touches nothing
  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!rd_o && !wr_o && !load_o && !step_o));

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              desel,
  input  logic              seq_linear,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              live_o,
  output logic [ADDR_W-1:0] eff_addr_o
);
  import sbsram_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cur_lo;
  logic [1:0]        nxt_lo;

  assign cur_lo = seq_map(base_q[1:0], cnt_q, seq_linear);
  assign nxt_lo = seq_map(base_q[1:0], cnt_q + 2'd1, seq_linear);

  always_comb begin
    if (load)      eff_addr_o = ext_addr;
    else if (step) eff_addr_o = {base_q[ADDR_W-1:2], nxt_lo};
    else           eff_addr_o = {base_q[ADDR_W-1:2], cur_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      live_o <= 1'b0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
      live_o <= 1'b1;
    end else if (desel) begin
      live_o <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  // R7: every new burst starts at beat zero
  p_load_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == 2'd0));

  // R6: without a start or step the burst position holds
  p_hold_position_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) mem[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sbsram_outstage.sv
module sbsram_outstage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cyc,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              pipe_sel,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic              rd_q;
  logic              rd_q2;
  logic [DATA_W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      rd_q2   <= 1'b0;
      raddr_o <= '0;
      pipe_q  <= '0;
    end else begin
      rd_q   <= rd_cyc;
      rd_q2  <= rd_q;
      pipe_q <= arr_data;
      if (rd_cyc) raddr_o <= eff_addr;
    end
  end

  assign rdata    = pipe_sel ? pipe_q : arr_data;
  assign rdata_oe = (pipe_sel ? rd_q2 : rd_q) && !out_en_n && !sleep;

  // R9: flow-through drive never lags a read edge
  p_flow_drive_r9: assert property (@(posedge clk) disable iff (rst)
    (!pipe_sel && !out_en_n && !sleep && $past(rd_cyc)) |-> rdata_oe);

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                cs0_n,
  input  logic                cs1,
  input  logic                cs2_n,
  input  logic                strobe_cpu_n,
  input  logic                strobe_ctl_n,
  input  logic                advance_n,
  input  logic                wr_all_n,
  input  logic                wr_byte_en_n,
  input  logic [DATA_W/8-1:0] lane_wr_n,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                out_en_n,
  input  logic                sleep,
  input  logic                pipe_sel,
  input  logic                seq_linear,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdata_oe
);
  localparam int LANES = DATA_W / 8;

  logic              load, step, desel, rd_cyc, wr_cyc, live;
  logic [LANES-1:0]  mask;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] arr_data;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n),
    .lane_wr_n(lane_wr_n), .sleep(sleep), .burst_live(live),
    .load_o(load), .step_o(step), .desel_o(desel),
    .rd_o(rd_cyc), .wr_o(wr_cyc), .mask_o(mask)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .load(load), .step(step), .desel(desel),
    .seq_linear(seq_linear), .ext_addr(addr),
    .live_o(live), .eff_addr_o(eff_addr)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(wr_cyc), .be(mask), .waddr(eff_addr), .wdata(wdata),
    .raddr(raddr), .rdata(arr_data)
  );

  sbsram_outstage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_cyc(rd_cyc), .eff_addr(eff_addr),
    .arr_data(arr_data), .pipe_sel(pipe_sel), .out_en_n(out_en_n),
    .sleep(sleep), .raddr_o(raddr), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // R6: with no live burst and no strobe, nothing is accessed
  p_no_orphan_access_r6: assert property (@(posedge clk) disable iff (rst)
    (!live && strobe_cpu_n && strobe_ctl_n) |-> (!wr_cyc && !rd_cyc));

endmodule

// File: tb/sbsram_core_test.sv
module sbsram_core_test;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          cs0_n, cs1, cs2_n, strobe_cpu_n, strobe_ctl_n, advance_n;
  logic          wr_all_n, wr_byte_en_n, out_en_n, sleep, pipe_sel, seq_linear;
  logic [3:0]    lane_wr_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  sbsram_core #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_wr_n(lane_wr_n),
    .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep), .pipe_sel(pipe_sel),
    .seq_linear(seq_linear), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #4 clk = ~clk;

  localparam logic [41:0] VEC [8] = '{
    {10'h000, 32'h0000_0001}, {10'h001, 32'hDEAD_BEEF},
    {10'h0FF, 32'h1234_5678}, {10'h155, 32'hA5A5_5A5A},
    {10'h2AA, 32'hFFFF_0000}, {10'h3FE, 32'h0F0F_F0F0},
    {10'h3FF, 32'h8000_0001}, {10'h200, 32'h7654_3210}
  };

  function automatic logic [31:0] val(input int a);
    return {8'hC3, 8'(a), 8'(~a), 8'h5A};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in;
    cs0_n = 0; cs1 = 1; cs2_n = 0;
    strobe_cpu_n = 1; strobe_ctl_n = 1; advance_n = 1;
    wr_all_n = 1; wr_byte_en_n = 1; lane_wr_n = 4'hF;
    sleep = 0;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; strobe_ctl_n = 0; wr_all_n = 0;
    tick;
    idle_in;
  endtask

  // flow-through read start; leaves the burst live
  task automatic rd_start(input logic [AW-1:0] a);
    addr = a; strobe_cpu_n = 0;
    tick;
    idle_in;
  endtask

  task automatic desel;
    strobe_ctl_n = 0; cs1 = 0;
    tick;
    idle_in;
  endtask

  initial begin
    rst = 1; addr = '0; wdata = '0; out_en_n = 0; pipe_sel = 0; seq_linear = 1;
    idle_in;
    repeat (3) tick;
    chk("R12 oe in reset", {31'd0, rdata_oe}, 32'd0);
    rst = 0;
    tick;
    chk("R12 idle after reset", {31'd0, rdata_oe}, 32'd0);

    // table: controller-strobe full writes, then processor-strobe reads
    foreach (VEC[i]) wr_word(VEC[i][41:32], VEC[i][31:0]);
    chk("R8 no drive on write", {31'd0, rdata_oe}, 32'd0);
    foreach (VEC[i]) begin
      rd_start(VEC[i][41:32]);
      chk("R2 table read data", rdata, VEC[i][31:0]);
      chk("R8 table read drive", {31'd0, rdata_oe}, 32'd1);
    end

    // R2: processor strobe ignores write inputs
    wr_word(10'h010, 32'h1111_1111);
    addr = 10'h010; wdata = 32'h9999_9999; strobe_cpu_n = 0; wr_all_n = 0;
    tick; idle_in;
    chk("R2 cpu strobe reads", rdata, 32'h1111_1111);

    // R4: all-bytes write overrides lanes
    addr = 10'h011; wdata = 32'hCAFE_F00D; strobe_ctl_n = 0; wr_all_n = 0;
    wr_byte_en_n = 1; lane_wr_n = 4'hF;
    tick; idle_in;
    rd_start(10'h011);
    chk("R4 all bytes", rdata, 32'hCAFE_F00D);

    // R5: lanes 0 and 2 only
    wr_word(10'h012, 32'h0);
    addr = 10'h012; wdata = 32'hFFFF_FFFF; strobe_ctl_n = 0;
    wr_byte_en_n = 0; lane_wr_n = 4'b1010;
    tick; idle_in;
    rd_start(10'h012);
    chk("R5 lanes 0,2", rdata, 32'h00FF_00FF);
    // R5/R3: lanes low but byte enable high -> controller-strobe read
    addr = 10'h012; wdata = 32'h0; strobe_ctl_n = 0; wr_byte_en_n = 1; lane_wr_n = 4'h0;
    tick; idle_in;
    chk("R3 ctl strobe read", rdata, 32'h00FF_00FF);
    chk("R5 read drive", {31'd0, rdata_oe}, 32'd1);

    // burst data
    for (int a = 'h40; a < 'h44; a++) wr_word(AW'(a), val(a));

    // R7 linear from 0x41 with wrap
    seq_linear = 1;
    rd_start(10'h041);
    chk("R7 lin beat0", rdata, val('h41));
    advance_n = 0;
    tick; chk("R7 lin beat1", rdata, val('h42));
    tick; chk("R7 lin beat2", rdata, val('h43));
    tick; chk("R7 lin beat3", rdata, val('h40));
    tick; chk("R7 lin wrap", rdata, val('h41));
    advance_n = 1;
    tick; chk("R6 hold keeps addr", rdata, val('h41));

    // R7 interleaved from 0x41
    seq_linear = 0;
    rd_start(10'h041);
    advance_n = 0;
    tick; chk("R7 ilv beat1", rdata, val('h40));
    tick; chk("R7 ilv beat2", rdata, val('h43));
    tick; chk("R7 ilv beat3", rdata, val('h42));
    tick; chk("R7 ilv wrap", rdata, val('h41));
    idle_in;
    seq_linear = 1;

    // R6 write burst: start, step, hold, byte step
    wr_word(10'h052, 32'h0);
    addr = 10'h050; wdata = 32'hD000_0000; strobe_ctl_n = 0; wr_all_n = 0;
    tick;
    strobe_ctl_n = 1; advance_n = 0; wdata = 32'hD111_1111;
    tick;
    advance_n = 1; wdata = 32'hD222_2222;
    tick;
    advance_n = 0; wr_all_n = 1; wr_byte_en_n = 0; lane_wr_n = 4'b1110; wdata = 32'hD333_3333;
    tick; idle_in;
    rd_start(10'h050); chk("R6 wburst start", rdata, 32'hD000_0000);
    rd_start(10'h051); chk("R6 wburst hold overwrite", rdata, 32'hD222_2222);
    rd_start(10'h052); chk("R6 wburst byte step", rdata, 32'h0000_0033);

    // R1: deselected strobe writes nothing and stops drive
    wr_word(10'h060, 32'h6060_6060);
    addr = 10'h060; wdata = 32'hBAD0_BAD0; strobe_ctl_n = 0; wr_all_n = 0; cs2_n = 1;
    tick; idle_in;
    chk("R1 deselect no drive", {31'd0, rdata_oe}, 32'd0);
    // R6: no live burst -> step with write inputs accesses nothing
    advance_n = 0; wr_all_n = 0; wdata = 32'hBAD1_BAD1;
    tick;
    chk("R6 orphan step no drive", {31'd0, rdata_oe}, 32'd0);
    idle_in;
    rd_start(10'h060);
    chk("R1 deselect kept data", rdata, 32'h6060_6060);

    // R8: asynchronous output enable
    out_en_n = 1; #1;
    chk("R8 oe high blocks", {31'd0, rdata_oe}, 32'd0);
    out_en_n = 0; #1;
    chk("R8 oe low drives", {31'd0, rdata_oe}, 32'd1);

    // R11 flow-through read after write
    wr_word(10'h070, 32'h7070_AAAA);
    rd_start(10'h070);
    chk("R11 flow raw", rdata, 32'h7070_AAAA);

    // R10: sleep blocks write, holds burst
    sleep = 1; #1;
    chk("R10 sleep forces no drive", {31'd0, rdata_oe}, 32'd0);
    addr = 10'h070; wdata = 32'hBAD2_BAD2; strobe_ctl_n = 0; wr_all_n = 0;
    tick; idle_in;
    rd_start(10'h070);
    chk("R10 sleep no write", rdata, 32'h7070_AAAA);
    rd_start(10'h040);
    sleep = 1; advance_n = 0;
    tick;
    chk("R10 sleep no read drive", {31'd0, rdata_oe}, 32'd0);
    sleep = 0;
    tick;
    chk("R10 burst held in sleep", rdata, val('h41));
    idle_in;

    // R9 pipeline timing and deselect lag
    desel;
    pipe_sel = 1;
    addr = 10'h042; strobe_cpu_n = 0;
    tick; idle_in;
    chk("R9 pipe not yet driving", {31'd0, rdata_oe}, 32'd0);
    tick;
    chk("R9 pipe drive", {31'd0, rdata_oe}, 32'd1);
    chk("R9 pipe data", rdata, val('h42));
    desel;
    chk("R9 pipe lag after deselect", {31'd0, rdata_oe}, 32'd1);
    tick;
    chk("R9 pipe stops", {31'd0, rdata_oe}, 32'd0);

    // R11 pipeline read after write
    wr_word(10'h071, 32'h7171_BBBB);
    addr = 10'h071; strobe_cpu_n = 0;
    tick; idle_in;
    tick;
    chk("R11 pipe raw", rdata, 32'h7171_BBBB);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule